// File: doc/BRIEF.md
# Low-Speed Oscillator Enable and Ready Control

This block is the control and status point for an external low-speed crystal oscillator of the 32 kHz class. Software sees one small register. It sets or clears the oscillator enable and chooses between running the crystal normally and passing an external clock straight through. It reads back a ready flag that hardware drives. The enable and bypass selections go to the analog oscillator cell on two output pins.

The ready flag comes from a small state machine that runs on the oscillator clock. It rises after a fixed number of oscillator cycles of settling time once enable is seen. Once enable is removed it holds for six more oscillator cycles and then falls. Enable crosses into the oscillator domain through a two-flop synchroniser, and ready returns to the bus domain the same way. The bypass selection cannot be changed while the oscillator is enabled.

Top module: `lso_ctrl`

## Requirements
- R1: After a synchronous reset, the register reads all zeros and both `osc_en_o` and `osc_byp_o` are 0.
- R2: Register bit 0 holds the enable. A write stores `wr_data[0]` there, and it appears on `osc_en_o` and in `rd_data[0]` on the next bus clock.
- R3: Register bit 1 reads as ready. With the default settling count of 8, after a write that sets enable from the off state, ready reads 1 in the bus domain first after the 11th rising edge of `osc_clk` and before the 12th. That is 2 synchroniser edges, 1 detect edge and 8 settling cycles.
- R4: After a write that clears enable while ready is 1, ready reads 0 in the bus domain first after the 9th rising `osc_clk` edge and before the 10th. That is 2 synchroniser edges, 1 detect edge and 6 hold cycles.
- R5: If enable is set again while ready is in its six-cycle hold, ready stays 1 without a gap and the settling count starts over.
- R6: If enable is removed before the settling count completes, ready never rises.
- R7: Register bit 2 holds the bypass (0 for crystal, 1 for external clock pass-through), driven on `osc_byp_o`. A write updates it when the stored enable is 0, including a write that sets enable and bypass together.
- R8: A write made while the stored enable is 1 leaves the bypass bit unchanged, even when that same write clears enable.
- R9: Register bits 3 and above always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| osc_clk | input | 1 | Low-speed oscillator clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read data |
| osc_en_o | output | 1 | Enable to the oscillator cell |
| osc_byp_o | output | 1 | Bypass select to the oscillator cell |

## Verification
The bench times both ready edges in oscillator cycles from the write. A design with an off-by-one counter or a missing synchroniser stage lands on the wrong edge, and one that drops ready as soon as enable clears fails the hold check. It re-enables in the middle of the hold and watches for any gap in ready, which a design that returns to the off state before restarting would show. It also pulses enable too briefly to settle, which catches a design that lets ready rise anyway. Bypass is written in the same write that sets enable, in the write that clears it, and while enabled, which exposes a lock that checks the incoming enable bit instead of the stored one.

// File: rtl/lso_pkg.sv
package lso_pkg;
  localparam int EN_BIT  = 0;
  localparam int RDY_BIT = 1;
  localparam int BYP_BIT = 2;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ON    = 2'd2,
    ST_HOLD  = 2'd3
  } osc_state_t;
endpackage

// File: rtl/lso_sync.sv
module lso_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lso_regs.sv
module lso_regs (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_en_bit,
  input  logic wr_byp_bit,
  output logic en_q,
  output logic byp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      byp_q <= 1'b0;
    end else if (wr_en) begin
      en_q <= wr_en_bit;
      if (!en_q) byp_q <= wr_byp_bit;
    end
  end
endmodule

// File: rtl/lso_ready_fsm.sv
module lso_ready_fsm
  import lso_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int HOLD_CYC   = 6
) (
  input  logic osc_clk,
  input  logic osc_rst,
  input  logic en_s,
  output logic ready
);
  localparam int MAXC = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  osc_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      state <= ST_OFF;
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          if (en_s) begin
            state <= ST_SETTLE;
            cnt   <= '0;
          end
        end
        ST_SETTLE: begin
          if (!en_s) begin
            cnt   <= '0;
            state <= ready ? ST_HOLD : ST_OFF;
          end else if (cnt == CW'(SETTLE_CYC - 1)) begin
            ready <= 1'b1;
            state <= ST_ON;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ON: begin
          if (!en_s) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end
        end
        ST_HOLD: begin
          if (en_s) begin
            state <= ST_SETTLE;
            cnt   <= '0;
          end else if (cnt == CW'(HOLD_CYC - 1)) begin
            ready <= 1'b0;
            state <= ST_OFF;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_OFF;
          cnt   <= '0;
          ready <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lso_ctrl.sv
module lso_ctrl
  import lso_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int SETTLE_CYC = 8,
  parameter int HOLD_CYC   = 6,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_clk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             osc_en_o,
  output logic             osc_byp_o
);
  logic en_q, byp_q, en_s, ready_osc, ready_bus, osc_rst;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:BYP_BIT+1], wr_data[RDY_BIT]};

  lso_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_en_bit  (wr_data[EN_BIT]),
    .wr_byp_bit (wr_data[BYP_BIT]),
    .en_q       (en_q),
    .byp_q      (byp_q)
  );

  lso_sync #(.W(1), .STAGES(SYNC_STG)) u_rst_osc (
    .clk (osc_clk), .rst (1'b0), .d (rst), .q (osc_rst)
  );

  lso_sync #(.W(1), .STAGES(SYNC_STG)) u_en_sync (
    .clk (osc_clk), .rst (osc_rst), .d (en_q), .q (en_s)
  );

  lso_ready_fsm #(.SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .osc_clk (osc_clk),
    .osc_rst (osc_rst),
    .en_s    (en_s),
    .ready   (ready_osc)
  );

  lso_sync #(.W(1), .STAGES(SYNC_STG)) u_rdy_sync (
    .clk (clk), .rst (rst), .d (ready_osc), .q (ready_bus)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[EN_BIT]  = en_q;
    rd_data[RDY_BIT] = ready_bus;
    rd_data[BYP_BIT] = byp_q;
  end

  assign osc_en_o  = en_q;
  assign osc_byp_o = byp_q;
endmodule

// File: rtl/lso_ctrl_chk.sv
module lso_ctrl_chk #(
  parameter int REG_W      = 8,
  parameter int SETTLE_CYC = 8,
  parameter int HOLD_CYC   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             osc_clk,
  input logic             osc_rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             en_q,
  input logic             byp_q,
  input logic             en_s,
  input logic             ready_osc
);
  localparam int MAXC = ((SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC) + 1;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] on_run, off_run;

  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      on_run  <= '0;
      off_run <= '0;
    end else begin
      on_run  <= !en_s ? '0 : (on_run  == CW'(MAXC) ? on_run  : on_run  + 1'b1);
      off_run <=  en_s ? '0 : (off_run == CW'(MAXC) ? off_run : off_run + 1'b1);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[0] == $past(wr_data[0])));

  assert_rise_count_R3: assert property (@(posedge osc_clk) disable iff (osc_rst)
    ($rose(ready_osc) && !$past(osc_rst)) |-> ($past(on_run) == CW'(SETTLE_CYC)));

  assert_fall_count_R4: assert property (@(posedge osc_clk) disable iff (osc_rst)
    ($fell(ready_osc) && !$past(osc_rst)) |-> ($past(off_run) == CW'(HOLD_CYC)));

  assert_byp_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en_q)) |-> $stable(byp_q));
endmodule

bind lso_ctrl lso_ctrl_chk #(
  .REG_W(REG_W), .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .en_q(en_q), .byp_q(byp_q), .en_s(en_s), .ready_osc(ready_osc)
);

// File: tb/sim_lso_ctrl.sv
module sim_lso_ctrl;
  localparam int CLK_HALF = 5;
  localparam int OSC_HALF = 16;
  localparam int REG_W    = 8;

  logic clk = 1'b0, osc_clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic osc_en_o, osc_byp_o;
  int osc_edges = 0;
  int n_run = 0, n_fail = 0;

  always #CLK_HALF clk = ~clk;
  always #OSC_HALF osc_clk = ~osc_clk;
  always @(posedge osc_clk) osc_edges++;

  lso_ctrl #(.REG_W(REG_W)) u0 (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .osc_en_o(osc_en_o), .osc_byp_o(osc_byp_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [REG_W-1:0] d, output int base);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    base = osc_edges;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_osc(input int base, input int n);
    while (osc_edges - base < n) @(negedge clk);
  endtask

  task automatic wait_ready(input logic tgt, input int base, output int edges);
    int guard = 0;
    while (rd_data[1] !== tgt && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    edges = osc_edges - base;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rd_data == '0, "R1 reg", int'(rd_data), 0);
    check(osc_en_o == 1'b0, "R1 en pin", int'(osc_en_o), 0);
    check(osc_byp_o == 1'b0, "R1 byp pin", int'(osc_byp_o), 0);
  endtask

  task automatic t_rise_fall();
    int b, e;
    write_reg(8'h01, b);
    check(rd_data[0] == 1'b1 && osc_en_o == 1'b1, "R2 set", int'(rd_data[0]), 1);
    wait_ready(1'b1, b, e);
    check(e == 11, "R3 rise edge", e, 11);
    write_reg(8'h00, b);
    check(rd_data[0] == 1'b0 && osc_en_o == 1'b0, "R2 clear", int'(rd_data[0]), 0);
    wait_ready(1'b0, b, e);
    check(e == 9, "R4 fall edge", e, 9);
  endtask

  task automatic t_short_pulse();
    int b, b2, seen = 0;
    write_reg(8'h01, b);
    wait_osc(b, 5);
    write_reg(8'h00, b2);
    while (osc_edges - b2 < 25) begin
      @(negedge clk);
      if (rd_data[1]) seen++;
    end
    check(seen == 0, "R6 no rise", seen, 0);
  endtask

  task automatic t_refire();
    int b, e, gaps = 0;
    write_reg(8'h01, b);
    wait_ready(1'b1, b, e);
    write_reg(8'h00, b);
    wait_osc(b, 3);
    check(rd_data[1] == 1'b1, "R4 held during hold", int'(rd_data[1]), 1);
    write_reg(8'h01, b);
    while (osc_edges - b < 30) begin
      @(negedge clk);
      if (!rd_data[1]) gaps++;
    end
    check(gaps == 0, "R5 no gap", gaps, 0);
    write_reg(8'h00, b);
    wait_ready(1'b0, b, e);
    check(e == 9, "R4 fall after refire", e, 9);
  endtask

  task automatic t_bypass();
    int b, e;
    write_reg(8'h04, b);
    check(rd_data[2] == 1'b1 && osc_byp_o == 1'b1, "R7 set off", int'(rd_data[2]), 1);
    write_reg(8'h00, b);
    check(rd_data[2] == 1'b0, "R7 clear off", int'(rd_data[2]), 0);
    write_reg(8'h05, b);
    check(rd_data[2:0] == 3'b101, "R7 set with enable", int'(rd_data[2:0]), 5);
    write_reg(8'h01, b);
    check(rd_data[2] == 1'b1 && osc_byp_o == 1'b1, "R8 locked on", int'(rd_data[2]), 1);
    write_reg(8'h00, b);
    check(rd_data[2] == 1'b1 && rd_data[0] == 1'b0, "R8 locked on disable write",
          int'(rd_data[2]), 1);
    write_reg(8'h00, b);
    check(rd_data[2] == 1'b0, "R7 clear after disable", int'(rd_data[2]), 0);
    wait_ready(1'b0, b, e);
  endtask

  task automatic t_upper();
    int b;
    write_reg(8'hF8, b);
    check(rd_data == '0, "R9 upper bits", int'(rd_data), 0);
  endtask

  initial begin
    repeat (20) @(posedge clk);
    rst = 1'b0;
    t_reset();
    repeat (20) @(posedge clk);
    t_rise_fall();
    t_short_pulse();
    t_refire();
    t_bypass();
    t_upper();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule